// File: doc/BRIEF.md
# Dimension-Order Route Computation Unit

This unit makes the per-hop output decision inside a router of a k-ary d-dimensional mesh or torus. A request carries the coordinates of the node the router sits in and the coordinates of the packet's destination. Each set of coordinates is a vector of `DIMS` digits, and each digit ranges from 0 to `RADIX-1`. The unit replies one cycle later with the output port the packet must take and the signed number of hops still needed in the dimension it chose.

Routing resolves the dimensions strictly in order, lowest index first. Each dimension has a plus-going and a minus-going port. In torus mode the offset in a dimension is reduced modulo the radix and the shorter way around the ring is taken. When both ways are equally long, the packet goes the plus way. A packet with no remaining offset in any dimension leaves through the local ejection port. The same unit therefore covers a plain mesh and a wraparound torus. With a radix of two it reduces to the rule of correcting the differing address bits in order, which is the binary hypercube rule.

The request side uses a valid/ready handshake. The response is held in a single output register with its own valid/ready pair, so a stalled consumer stalls the requester.

Top module: `dor_route_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted at a clock edge (`in_valid` and `in_ready` both 1) is reported at the next edge: `out_valid` is 1 with the result of that request. With no new request and `out_ready` at 1, `out_valid` returns to 0 after one cycle.
- R3: When the destination equals the source in every dimension, `out_port` is `2*DIMS` (local ejection) and `out_hops` is 0.
- R4: The dimension chosen is the lowest-numbered one with a nonzero offset. Dimension i uses port `2*i` for the plus direction and port `2*i+1` for the minus direction. A positive `out_hops` always goes with an even port.
- R5: In mesh mode, `out_hops` equals destination digit minus source digit in the chosen dimension. The value can be as large as ±(`RADIX-1`).
- R6: In torus mode, the offset w = (destination − source) mod `RADIX` is reported as w when 2w < `RADIX` and as w − `RADIX` when 2w > `RADIX`. Its magnitude never exceeds `RADIX/2`.
- R7: In torus mode with an even radix, an offset of exactly `RADIX/2` goes the plus way (`out_hops` = +`RADIX/2`). With a radix of two, every differing digit is therefore corrected with +1 on the even port of that dimension.
- R8: If any destination digit is `RADIX` or more, `out_err` is 1, `out_port` is `2*DIMS` and `out_hops` is 0. Otherwise `out_err` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the response outputs hold their values. When `out_ready` rises, a waiting request is accepted at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| src_coord | input | DIMS*CW | Local node digits, dimension i at bits [i*CW +: CW] |
| dst_coord | input | DIMS*CW | Destination digits, same packing |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_port | output | PW | Chosen port: 2i plus, 2i+1 minus, 2*DIMS local |
| out_hops | output | CW+1 | Signed hops remaining in the chosen dimension |
| out_err | output | 1 | Destination digit out of range |

## Verification
The bench targets the point where the shorter way around the ring flips. With a radix of five, an offset of +4 has to become −1 and an offset of −4 has to become +1. A design that wraps wrongly reports the long way, or the wrong sign and port. The even-radix tie is tested on a radix-two instance, where a design that breaks the tie toward minus selects the odd port. The bench checks dimension order with a zero offset in the low dimensions, which catches a design that scans from the top dimension. It checks out-of-range destination digits in both the lowest and the highest dimension, which catches a design that routes such a packet onto the network. A stalled response test catches a design that lets a new request overwrite the held result.

// File: rtl/dor_pkg.sv
package dor_pkg;

    typedef enum logic {
        TOPO_MESH  = 1'b0,
        TOPO_TORUS = 1'b1
    } topo_e;

    function automatic int plus_port(input int dim);
        return 2 * dim;
    endfunction

    function automatic int minus_port(input int dim);
        return 2 * dim + 1;
    endfunction

    function automatic int eject_port(input int dims);
        return 2 * dims;
    endfunction

    function automatic int digit_bits(input int radix);
        return (radix > 2) ? $clog2(radix) : 1;
    endfunction

endpackage

// File: rtl/dor_offset.sv
module dor_offset
    import dor_pkg::*;
#(
    parameter int    RADIX = 5,
    parameter topo_e TOPO  = TOPO_TORUS,
    parameter int    CW    = 3,
    parameter int    HW    = 4
) (
    input  logic [CW-1:0]        src_digit,
    input  logic [CW-1:0]        dst_digit,
    output logic signed [HW-1:0] hops,
    output logic                 bad_digit
);
    int diff;
    int res;

    always_comb begin
        diff      = int'(dst_digit) - int'(src_digit);
        bad_digit = int'(dst_digit) >= RADIX;
    end

    generate
        if (TOPO == TOPO_TORUS) begin : g_torus
            int wrap;
            always_comb begin
                wrap = (diff < 0) ? diff + RADIX : diff;
                // ties at exactly half the ring go the plus way
                res  = (2 * wrap > RADIX) ? wrap - RADIX : wrap;
            end
        end else begin : g_mesh
            always_comb res = diff;
        end
    endgenerate

    assign hops = HW'(res);

endmodule

// File: rtl/dor_pick.sv
module dor_pick
    import dor_pkg::*;
#(
    parameter int DIMS = 3,
    parameter int HW   = 4,
    parameter int PW   = 3
) (
    input  logic [DIMS-1:0][HW-1:0] hop_vec,
    input  logic                    bad_any,
    output logic [PW-1:0]           port,
    output logic signed [HW-1:0]    hops
);
    logic found;

    always_comb begin
        port  = PW'(eject_port(DIMS));
        hops  = '0;
        found = 1'b0;
        for (int i = 0; i < DIMS; i++) begin
            if (!found && hop_vec[i] != '0) begin
                found = 1'b1;
                hops  = $signed(hop_vec[i]);
                port  = hop_vec[i][HW-1] ? PW'(minus_port(i)) : PW'(plus_port(i));
            end
        end
        if (bad_any) begin
            port = PW'(eject_port(DIMS));
            hops = '0;
        end
    end

endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
    import dor_pkg::*;
#(
    parameter int    RADIX = 5,
    parameter int    DIMS  = 3,
    parameter topo_e TOPO  = TOPO_TORUS,
    localparam int   CW    = digit_bits(RADIX),
    localparam int   HW    = CW + 1,
    localparam int   PW    = $clog2(2 * DIMS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DIMS*CW-1:0]   src_coord,
    input  logic [DIMS*CW-1:0]   dst_coord,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PW-1:0]        out_port,
    output logic signed [HW-1:0] out_hops,
    output logic                 out_err
);
    localparam int LOCAL = eject_port(DIMS);

    logic [DIMS-1:0][HW-1:0] hop_vec;
    logic [DIMS-1:0]         bad_vec;
    logic [PW-1:0]           nxt_port;
    logic signed [HW-1:0]    nxt_hops;
    logic                    accept;

    generate
        for (genvar g = 0; g < DIMS; g++) begin : g_dim
            logic signed [HW-1:0] h;
            dor_offset #(.RADIX(RADIX), .TOPO(TOPO), .CW(CW), .HW(HW)) u_off (
                .src_digit (src_coord[g*CW +: CW]),
                .dst_digit (dst_coord[g*CW +: CW]),
                .hops      (h),
                .bad_digit (bad_vec[g])
            );
            assign hop_vec[g] = h;
        end
    endgenerate

    dor_pick #(.DIMS(DIMS), .HW(HW), .PW(PW)) u_pick (
        .hop_vec (hop_vec),
        .bad_any (|bad_vec),
        .port    (nxt_port),
        .hops    (nxt_hops)
    );

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_hops  <= '0;
            out_err   <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_port  <= nxt_port;
            out_hops  <= nxt_hops;
            out_err   <= |bad_vec;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid); // R2

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_port)
                                    && $stable(out_hops) && $stable(out_err)); // R9

    AST_ERR_EJECT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_err |-> int'(out_port) == LOCAL && out_hops == '0); // R8

    AST_EJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && int'(out_port) == LOCAL |-> out_hops == '0); // R3

    AST_SIGN_PORT: assert property (@(posedge clk) disable iff (rst)
        out_valid && int'(out_port) < LOCAL |-> (out_port[0] == 1'b0) == (out_hops > 0)); // R4

    generate
        if (TOPO == TOPO_TORUS) begin : g_short_chk
            AST_TORUS_SHORT: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> 2 * int'(out_hops) <= RADIX && 2 * int'(out_hops) >= -RADIX); // R6
        end
    endgenerate

endmodule

// File: tb/dor_route_unit_tb.sv
`timescale 1ns/1ps
module dor_route_unit_tb;
    import dor_pkg::*;

    localparam int K  = 5;
    localparam int D  = 3;
    localparam int CW = 3;
    localparam int HW = 4;
    localparam int PW = 3;
    localparam int HD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              vld = 1'b0;
    logic              ordy = 1'b1;
    logic [D*CW-1:0]   src = '0;
    logic [D*CW-1:0]   dst = '0;

    logic              m_irdy, m_ov, m_err;
    logic [PW-1:0]     m_port;
    logic signed [HW-1:0] m_hops;
    logic              t_irdy, t_ov, t_err;
    logic [PW-1:0]     t_port;
    logic signed [HW-1:0] t_hops;

    logic              h_vld = 1'b0;
    logic [HD-1:0]     h_src = '0;
    logic [HD-1:0]     h_dst = '0;
    logic              h_irdy, h_ov, h_err;
    logic [3:0]        h_port;
    logic signed [1:0] h_hops;

    int checks = 0;
    int errors = 0;

    dor_route_unit #(.RADIX(K), .DIMS(D), .TOPO(TOPO_TORUS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(vld), .in_ready(t_irdy),
        .src_coord(src), .dst_coord(dst), .out_valid(t_ov), .out_ready(ordy),
        .out_port(t_port), .out_hops(t_hops), .out_err(t_err));

    dor_route_unit #(.RADIX(K), .DIMS(D), .TOPO(TOPO_MESH)) u_mesh (
        .clk(clk), .rst(rst), .in_valid(vld), .in_ready(m_irdy),
        .src_coord(src), .dst_coord(dst), .out_valid(m_ov), .out_ready(ordy),
        .out_port(m_port), .out_hops(m_hops), .out_err(m_err));

    dor_route_unit #(.RADIX(2), .DIMS(HD), .TOPO(TOPO_TORUS)) u_cube (
        .clk(clk), .rst(rst), .in_valid(h_vld), .in_ready(h_irdy),
        .src_coord(h_src), .dst_coord(h_dst), .out_valid(h_ov), .out_ready(1'b1),
        .out_port(h_port), .out_hops(h_hops), .out_err(h_err));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void ref_route(input int k, input int nd, input bit torus,
                                      input int s[4], input int t[4],
                                      output int port, output int hops, output bit err);
        err = 0;
        port = 2 * nd;
        hops = 0;
        for (int i = 0; i < nd; i++) if (t[i] >= k) err = 1;
        if (err) return;
        for (int i = 0; i < nd; i++) begin
            int h;
            h = t[i] - s[i];
            if (torus) begin
                h = ((h % k) + k) % k;
                if (2 * h > k) h = h - k;
            end
            if (h != 0) begin
                hops = h;
                port = (h > 0) ? 2 * i : 2 * i + 1;
                return;
            end
        end
    endfunction

    function automatic logic [D*CW-1:0] pack(input int a[4]);
        return {3'(a[2]), 3'(a[1]), 3'(a[0])};
    endfunction

    task automatic check_both(input int s[4], input int t[4], input string req);
        int ep, eh;
        bit ee;
        ref_route(K, D, 1'b0, s, t, ep, eh, ee);
        chk(m_ov == 1'b1, req, "mesh valid", int'(m_ov), 1);
        chk(int'(m_port) == ep, req, "mesh port", int'(m_port), ep);
        chk(int'(m_hops) == eh, req, "mesh hops", int'(m_hops), eh);
        chk(m_err == ee, req, "mesh err", int'(m_err), int'(ee));
        ref_route(K, D, 1'b1, s, t, ep, eh, ee);
        chk(t_ov == 1'b1, req, "torus valid", int'(t_ov), 1);
        chk(int'(t_port) == ep, req, "torus port", int'(t_port), ep);
        chk(int'(t_hops) == eh, req, "torus hops", int'(t_hops), eh);
        chk(t_err == ee, req, "torus err", int'(t_err), int'(ee));
    endtask

    task automatic route_case(input int s[4], input int t[4], input string req);
        @(negedge clk);
        vld = 1'b1;
        src = pack(s);
        dst = pack(t);
        @(negedge clk);
        vld = 1'b0;
        check_both(s, t, req);
    endtask

    task automatic test_reset();
        chk(t_ov == 1'b0 && m_ov == 1'b0, "R1", "out_valid after reset", int'(t_ov), 0);
        chk(t_irdy == 1'b1 && m_irdy == 1'b1, "R1", "in_ready after reset", int'(t_irdy), 1);
    endtask

    task automatic test_latency();
        route_case('{1, 2, 3, 0}, '{1, 2, 0, 0}, "R2");
        @(negedge clk);
        chk(t_ov == 1'b0, "R2", "valid drops when idle", int'(t_ov), 0);
    endtask

    task automatic test_zero();
        route_case('{1, 2, 3, 0}, '{1, 2, 3, 0}, "R3");
        route_case('{0, 0, 0, 0}, '{0, 0, 0, 0}, "R3");
    endtask

    task automatic test_order();
        route_case('{2, 1, 4, 0}, '{2, 3, 0, 0}, "R4");
        route_case('{3, 3, 3, 0}, '{3, 3, 1, 0}, "R4");
        route_case('{0, 4, 0, 0}, '{1, 0, 4, 0}, "R4");
    endtask

    task automatic test_mesh_torus();
        route_case('{0, 0, 0, 0}, '{4, 0, 0, 0}, "R5");
        route_case('{4, 0, 0, 0}, '{0, 0, 0, 0}, "R6");
        route_case('{0, 1, 0, 0}, '{0, 4, 0, 0}, "R6");
        route_case('{0, 0, 1, 0}, '{0, 0, 3, 0}, "R6");
        route_case('{0, 0, 3, 0}, '{0, 0, 0, 0}, "R6");
    endtask

    task automatic test_range();
        route_case('{0, 0, 0, 0}, '{6, 0, 0, 0}, "R8");
        route_case('{2, 2, 2, 0}, '{2, 2, 5, 0}, "R8");
        route_case('{2, 2, 2, 0}, '{1, 2, 7, 0}, "R8");
    endtask

    task automatic test_stall();
        int ep, eh;
        bit ee;
        @(negedge clk);
        ordy = 1'b0;
        vld  = 1'b1;
        src  = pack('{0, 0, 0, 0});
        dst  = pack('{0, 2, 0, 0});
        @(negedge clk);
        src  = pack('{0, 0, 0, 0});
        dst  = pack('{0, 0, 4, 0});
        chk(t_irdy == 1'b0, "R9", "in_ready during stall", int'(t_irdy), 0);
        @(negedge clk);
        ref_route(K, D, 1'b1, '{0, 0, 0, 0}, '{0, 2, 0, 0}, ep, eh, ee);
        chk(int'(t_port) == ep, "R9", "held port", int'(t_port), ep);
        chk(int'(t_hops) == eh, "R9", "held hops", int'(t_hops), eh);
        ordy = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        check_both('{0, 0, 0, 0}, '{0, 0, 4, 0}, "R9");
    endtask

    task automatic cube_case(input logic [HD-1:0] s, input logic [HD-1:0] t, input string req);
        int sa[4], ta[4];
        int ep, eh;
        bit ee;
        for (int i = 0; i < HD; i++) begin
            sa[i] = int'(s[i]);
            ta[i] = int'(t[i]);
        end
        ref_route(2, HD, 1'b1, sa, ta, ep, eh, ee);
        @(negedge clk);
        h_vld = 1'b1;
        h_src = s;
        h_dst = t;
        @(negedge clk);
        h_vld = 1'b0;
        chk(h_ov == 1'b1, req, "cube valid", int'(h_ov), 1);
        chk(int'(h_port) == ep, req, "cube port", int'(h_port), ep);
        chk(int'(h_hops) == eh, req, "cube hops", int'(h_hops), eh);
    endtask

    task automatic test_cube();
        cube_case(4'b0101, 4'b0110, "R7");
        cube_case(4'b0000, 4'b1000, "R7");
        cube_case(4'b1110, 4'b0110, "R7");
        cube_case(4'b1010, 4'b1010, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_latency();
        test_zero();
        test_order();
        test_mesh_torus();
        test_range();
        test_stall();
        test_cube();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule